// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit keeps the event status, interrupt enables, interrupt vector and DMA control of a bus-mapped I2C master controller. The controller's sequencer and buffer logic report what happened on the bus as single-cycle event pulses. The unit latches each pulse as a sticky status bit. It drives one level-sensitive interrupt line and two DMA request lines, one per direction.

Software reaches the unit through a 16-bit register port. A read returns data combinationally while the read strobe is high, and any side effect of the read takes place at the clock edge that ends that cycle. A read of the vector register returns the 1-based position of the lowest enabled pending status bit and acknowledges that bit. Interrupt service is therefore a loop of vector reads that ends when a read returns zero. When DMA is turned on for a direction, the ready interrupt for that direction is switched off, so the data mover and the processor do not both answer the same ready event.

Register selects (regSel): 0 revision, 1 interrupt enable, 2 status, 3 vector, 4 DMA control, 5 to 7 unmapped.

Top module: `i2cIntUnit`

## Requirements
- R1: After reset the status, interrupt-enable and DMA-control registers read 0, irq and both DMA requests are low, and a read of the revision register (select 0) returns 0x0011.
- R2: eventPulse bits 0..7 set the sticky status bits NACK=1, ARDY=2, RRDY=3, XRDY=4, AAS=9, XUDF=10, ROVR=11 and SBD=15. Only reset and a vector acknowledge clear them.
- R3: The interrupt-enable register (select 1) keeps wrData[4:0] and reads as zero above bit 4. irq is high exactly when some status bit 0..4 is set and its enable bit is also set.
- R4: A read of the vector register (select 3) returns 1 + the position of the lowest set bit of (status[4:0] AND enable), or 0 when there is none. At the end of that cycle, that status bit is cleared.
- R5: Only a vector read has a side effect: one read cycle clears exactly one bit. Reads of the other registers change no state.
- R6: A write to the DMA-control register (select 4) keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing a 1 to bit 15 clears enable bit 3, and writing a 1 to bit 7 clears enable bit 4.
- R7: dmaRxReq equals receive-DMA-enable AND status RRDY. dmaTxReq equals transmit-DMA-enable AND status XRDY. Both are low while their enable is 0.
- R8: A status read (select 2) returns the stored bits with bit 12 replaced by the live busBusy input.
- R9: Writes to the revision, status and vector registers are ignored.
- R10: An event pulse that arrives in the same cycle as a vector acknowledge of the same bit leaves that bit set.
- R11: Selects 5 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 3 | Register select |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid while rdEn is high, 0 otherwise |
| eventPulse | input | 8 | Event pulses from the controller, order as in R2 |
| busBusy | input | 1 | Live bus-busy flag |
| irq | output | 1 | Level interrupt |
| dmaRxReq | output | 1 | Receive DMA request |
| dmaTxReq | output | 1 | Transmit DMA request |

## Verification
A status bit that fails to latch or clear shows at irq and in the status readback one cycle after the event pulse. A wrong priority order in the vector encoder shows in the first vector read after two or more causes are pending. The bench sweeps every enable mask against every combination of the four low-order events and drains each case with vector reads, so a wrong acknowledge leaves a stale nonzero vector or a raised irq within one read. DMA masking and request gating show at the enable readback and at the request pins on the cycle after the write.

// File: rtl/i2cIntPkg.sv
package i2cIntPkg;
  localparam int STAT_W = 16;
  localparam int IE_W   = 5;
  localparam int EVT_N  = 8;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_REV  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_IE   = 3'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_VEC  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DMA  = 3'd4;

  localparam int POS_RRDY   = 3;
  localparam int POS_XRDY   = 4;
  localparam int POS_BUSY   = 12;
  localparam int DMA_RX_BIT = 15;
  localparam int DMA_TX_BIT = 7;
  localparam logic [STAT_W-1:0] DMA_KEEP = (STAT_W'(1) << DMA_RX_BIT) | (STAT_W'(1) << DMA_TX_BIT);

  // status position of each event input
  function automatic int evtPos(input int idx);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 15;
    endcase
  endfunction

  typedef struct packed {
    logic wrIe;
    logic wrDma;
    logic rdVec;
  } regStrobe_t;
endpackage

// File: rtl/i2cIntCtrl.sv
module i2cIntCtrl
  import i2cIntPkg::*;
(
  input  logic [SEL_W-1:0] regSel,
  input  logic             rdEn,
  input  logic             wrEn,
  output regStrobe_t       strobes
);
  always_comb begin
    strobes.wrIe  = wrEn && (regSel == SEL_IE);
    strobes.wrDma = wrEn && (regSel == SEL_DMA);
    strobes.rdVec = rdEn && (regSel == SEL_VEC);
  end
endmodule

// File: rtl/i2cIntDatapath.sv
module i2cIntDatapath
  import i2cIntPkg::*;
#(
  parameter logic [STAT_W-1:0] REV_CODE = 16'h0011
)(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              rdEn,
  input  logic [STAT_W-1:0] wrData,
  input  logic [EVT_N-1:0]  eventPulse,
  input  logic              busBusy,
  output logic [STAT_W-1:0] rdData,
  output logic              irq,
  output logic              dmaRxReq,
  output logic              dmaTxReq
);
  logic [STAT_W-1:0] statusQ;
  logic [IE_W-1:0]   intEnQ;
  logic [STAT_W-1:0] dmaCtrlQ;
  logic [STAT_W-1:0] setMask;
  logic [STAT_W-1:0] hitOneHot;
  logic [STAT_W-1:0] clearMask;
  logic [STAT_W-1:0] vecCode;
  logic [IE_W-1:0]   pending;
  logic [STAT_W-1:0] statusView;

  always_comb begin
    setMask = '0;
    for (int i = 0; i < EVT_N; i++) setMask[evtPos(i)] = eventPulse[i];
  end

  assign pending = statusQ[IE_W-1:0] & intEnQ;

  // lowest pending position wins: scan from the top down
  always_comb begin
    vecCode   = '0;
    hitOneHot = '0;
    for (int i = IE_W - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vecCode   = STAT_W'(i + 1);
        hitOneHot = STAT_W'(1) << i;
      end
    end
  end

  assign clearMask = strobes.rdVec ? hitOneHot : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      intEnQ   <= '0;
      dmaCtrlQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clearMask) | setMask;
      if (strobes.wrIe) begin
        intEnQ <= wrData[IE_W-1:0];
      end else if (strobes.wrDma) begin
        intEnQ[POS_RRDY] <= intEnQ[POS_RRDY] & ~wrData[DMA_RX_BIT];
        intEnQ[POS_XRDY] <= intEnQ[POS_XRDY] & ~wrData[DMA_TX_BIT];
      end
      if (strobes.wrDma) dmaCtrlQ <= wrData & DMA_KEEP;
    end
  end

  always_comb begin
    statusView           = statusQ;
    statusView[POS_BUSY] = busBusy;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (regSel)
        SEL_REV:  rdData = REV_CODE;
        SEL_IE:   rdData = STAT_W'(intEnQ);
        SEL_STAT: rdData = statusView;
        SEL_VEC:  rdData = vecCode;
        SEL_DMA:  rdData = dmaCtrlQ;
        default:  rdData = '0;
      endcase
    end
  end

  assign irq      = |pending;
  assign dmaRxReq = dmaCtrlQ[DMA_RX_BIT] & statusQ[POS_RRDY];
  assign dmaTxReq = dmaCtrlQ[DMA_TX_BIT] & statusQ[POS_XRDY];
endmodule

// File: rtl/i2cIntUnit.sv
module i2cIntUnit
  import i2cIntPkg::*;
#(
  parameter logic [15:0] REV_CODE = 16'h0011
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regSel,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  input  logic [7:0]  eventPulse,
  input  logic        busBusy,
  output logic        irq,
  output logic        dmaRxReq,
  output logic        dmaTxReq
);
  regStrobe_t strobes;

  i2cIntCtrl u_ctrl (
    .regSel (regSel),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .strobes(strobes)
  );

  i2cIntDatapath #(.REV_CODE(REV_CODE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regSel    (regSel),
    .rdEn      (rdEn),
    .wrData    (wrData),
    .eventPulse(eventPulse),
    .busBusy   (busBusy),
    .rdData    (rdData),
    .irq       (irq),
    .dmaRxReq  (dmaRxReq),
    .dmaTxReq  (dmaTxReq)
  );
endmodule

// File: rtl/i2cIntChecker.sv
module i2cIntChecker #(
  parameter logic [15:0] REV_CODE = 16'h0011
)(
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  regSel,
  input logic        rdEn,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        busBusy,
  input logic        irq,
  input logic        dmaRxReq
);
  AST_REV_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd0) |-> rdData == REV_CODE); // R1
  AST_NO_IRQ_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd1 && rdData == 16'd0) |-> !irq); // R3
  AST_VEC_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd3 && rdData == 16'd0) |-> !irq); // R4
  AST_VEC_HIT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd3 && rdData != 16'd0) |-> irq); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd3) |-> rdData <= 16'd5); // R4
  AST_DMA_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd4) |-> (rdData & 16'h7f7f) == 16'd0); // R6
  AST_DMA_MASKS_IE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd4 && wrData[15]) ##1 (rdEn && regSel == 3'd1) |-> !rdData[3]); // R6
  AST_RXREQ_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd4 && !wrData[15]) |=> !dmaRxReq); // R7
  AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regSel == 3'd2) |-> rdData[12] == busBusy); // R8
endmodule

bind i2cIntUnit i2cIntChecker #(.REV_CODE(REV_CODE)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .regSel (regSel),
  .rdEn   (rdEn),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData),
  .busBusy(busBusy),
  .irq    (irq),
  .dmaRxReq(dmaRxReq)
);

// File: tb/sim_i2cIntUnit.sv
module sim_i2cIntUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [7:0]  eventPulse = '0;
  logic        busBusy = 1'b0;
  logic        irq, dmaRxReq, dmaTxReq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2cIntUnit u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .eventPulse(eventPulse), .busBusy(busBusy),
    .irq(irq), .dmaRxReq(dmaRxReq), .dmaTxReq(dmaTxReq)
  );

  function automatic int posOf(input int idx);
    int tbl[8] = '{1, 2, 3, 4, 9, 10, 11, 15};
    return tbl[idx];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [15:0] val);
    @(negedge clk); wrEn = 1'b1; regSel = sel; wrData = val;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] sel, output logic [15:0] val);
    @(negedge clk); rdEn = 1'b1; regSel = sel;
    #1 val = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); eventPulse = m;
    @(negedge clk); eventPulse = '0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    doReset();
    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 dma req", {14'd0, dmaRxReq, dmaTxReq}, 16'd0);
    readReg(3'd2, v); check("R1 status", v, 16'd0);
    readReg(3'd1, v); check("R1 ie", v, 16'd0);
    readReg(3'd4, v); check("R1 dma", v, 16'd0);
    readReg(3'd0, v); check("R1 rev", v, 16'h0011);

    // R2 each event sets its own bit
    for (int k = 0; k < 8; k++) begin
      doReset();
      pulse(8'(1 << k));
      readReg(3'd2, v); check("R2 event map", v, 16'(1 << posOf(k)));
      readReg(3'd2, v); check("R5 status read no side effect", v, 16'(1 << posOf(k)));
    end

    // R8 bus busy live
    doReset();
    pulse(8'hff);
    for (int b = 0; b < 2; b++) begin
      busBusy = b[0];
      readReg(3'd2, v); check("R8 busy bit", v, 16'h8e1e | (b[0] ? 16'h1000 : 16'h0));
    end
    busBusy = 1'b0;

    // R3 ie width
    writeReg(3'd1, 16'hffff);
    readReg(3'd1, v); check("R3 ie width", v, 16'h001f);

    // R3 R4 sweep: every mask against every low-event subset
    for (int m = 0; m < 32; m++) begin
      for (int s = 0; s < 16; s++) begin
        logic [4:0] st;
        doReset();
        writeReg(3'd1, 16'(m));
        pulse(8'(s));
        st = 5'(s << 1);
        for (int n = 0; n < 6; n++) begin
          logic [4:0] pend;
          int exp;
          pend = st & 5'(m);
          exp = 0;
          for (int b = 4; b >= 0; b--) if (pend[b]) exp = b + 1;
          check("R3 irq level", {15'd0, irq}, {15'd0, pend != 0});
          readReg(3'd3, v); check("R4 vector", v, 16'(exp));
          if (exp == 0) break;
          st[exp-1] = 1'b0;
        end
      end
    end

    // R6 dma register and enable masking
    doReset();
    writeReg(3'd1, 16'h001f);
    writeReg(3'd4, 16'hffff);
    readReg(3'd4, v); check("R6 dma keep", v, 16'h8080);
    readReg(3'd1, v); check("R6 ie masked", v, 16'h0007);
    writeReg(3'd1, 16'h001f);
    writeReg(3'd4, 16'h0080);
    readReg(3'd1, v); check("R6 tx only masks bit4", v, 16'h000f);

    // R7 requests follow ready bits
    doReset();
    writeReg(3'd4, 16'h8080);
    check("R7 idle", {14'd0, dmaRxReq, dmaTxReq}, 16'd0);
    pulse(8'h04);
    check("R7 rx req", {14'd0, dmaRxReq, dmaTxReq}, 16'd2);
    pulse(8'h08);
    check("R7 both", {14'd0, dmaRxReq, dmaTxReq}, 16'd3);
    writeReg(3'd4, 16'h0000);
    check("R7 disabled", {14'd0, dmaRxReq, dmaTxReq}, 16'd0);

    // R9 R11 ignored writes
    doReset();
    pulse(8'h81);
    writeReg(3'd1, 16'h0002);
    writeReg(3'd0, 16'hffff);
    writeReg(3'd2, 16'h0000);
    writeReg(3'd3, 16'hffff);
    for (int a = 5; a < 8; a++) writeReg(3'(a), 16'hffff);
    readReg(3'd0, v); check("R9 rev kept", v, 16'h0011);
    readReg(3'd2, v); check("R9 status kept", v, 16'h8002);
    readReg(3'd1, v); check("R11 ie kept", v, 16'h0002);
    readReg(3'd4, v); check("R11 dma kept", v, 16'h0000);
    for (int a = 5; a < 8; a++) begin
      readReg(3'(a), v); check("R11 unmapped read", v, 16'h0000);
    end

    // R10 event coinciding with acknowledge
    @(negedge clk); rdEn = 1'b1; regSel = 3'd3; eventPulse = 8'h01;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0; eventPulse = '0;
    check("R10 first vector", v, 16'd2);
    check("R10 irq held", {15'd0, irq}, 16'd1);
    readReg(3'd3, v); check("R10 bit survived", v, 16'd2);
    readReg(3'd3, v); check("R5 one clear per read", v, 16'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule